// File: doc/BRIEF.md
# Lag Correlator Sub-Block

This block cross-correlates two streams of 2-bit quantised samples over a row of lags (64 by default). The first stream is presented to every lag at once. The second stream moves down a sample delay line, one stage per lag. Each lag maps its pair of samples to a small non-negative product code and adds that code into a private running sum. That sum is split into a narrow fast accumulator, a short prescaler and a wide upper counter.

A dump request closes the current integration interval. Every running sum is copied into a storage word and cleared in the same cycle. In normal use the dump comes once per millisecond of the 125 MHz sample clock. While blanking is asserted, samples still move along the delay line but add nothing to the sums. An optional lead stage adds one more delay in front of the line. The stored words are read through an index-addressed readout port.

Top module: `lagcorr_top`

## Requirements
- R1: Sample codes mean 00 = -3, 01 = -1, 10 = +1, 11 = +3. A lag adds (x*y + 9)/2 per accepted sample. This gives 9, 6, 5, 4, 3 or 0 for the products +9, +3, +1, -1, -3 and -9.
- R2: Lag k pairs the current `x_smp` with the `y_smp` value taken k valid samples earlier. The delay line advances only in cycles where `smp_vld` is 1. Before any samples arrive, the line holds code 00.
- R3: With `lead_en` held at 1, lag k instead pairs `x_smp` with the `y_smp` value taken k+1 valid samples earlier.
- R4: Each running sum is exact across the carries from the 5-bit fast accumulator into the 4-bit prescaler, and from the prescaler into the upper counter.
- R5: A sample that arrives while `blank` is 1 adds nothing to any sum, but it still advances the delay line.
- R6: On a cycle with `dump` at 1, each lag's storage word takes the sum of all samples accepted since the previous dump, and each running sum restarts from zero.
- R7: A valid sample that arrives in the same cycle as `dump` counts in neither interval. The sample accepted in the cycle just before the dump is still counted in the interval that closes.
- R8: A storage word saturates at 65535 when the interval sum exceeds it.
- R9: After reset, every storage word reads 0 until the first dump.
- R10: Storage words change only on a dump. Between dumps, `rd_data` for a fixed `rd_idx` is constant.
- R11: `rd_data` shows the storage word of the lag selected by `rd_idx`, combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| x_smp | input | 2 | Broadcast sample stream |
| y_smp | input | 2 | Delayed sample stream |
| smp_vld | input | 1 | Both samples are valid this cycle |
| blank | input | 1 | Suppress accumulation |
| dump | input | 1 | Close the interval: copy the sums to storage and clear them |
| lead_en | input | 1 | Insert one extra delay stage before lag 0 |
| rd_idx | input | 6 | Lag index to read |
| rd_data | output | 16 | Stored word of the selected lag |

## Verification
The checker assumes `dump` is a single-cycle level that the driver raises on its own schedule. It also assumes `rd_idx` changes only between clock edges, so a word that holds between dumps shows up as a stable `rd_data`. The upper bound it places on a freshly stored word counts the samples accepted since the last dump, using the same valid, blank and dump inputs the lags see. The stimulus changes every input half a period away from the rising edge. It holds `lead_en` fixed between resets, and it sets `dump` high for exactly one cycle per interval.

// File: rtl/lagcorr_pkg.sv
package lagcorr_pkg;

    typedef logic [1:0] smp_t;

    // Non-negative product code (x*y + 9)/2 for the four-level encoding.
    // A sample is large (|3|) when both of its bits are equal; bit 1 is the sign.
    function automatic logic [3:0] prod_code(smp_t a, smp_t b);
        logic big_a;
        logic big_b;
        logic same;
        logic [3:0] r;
        big_a = ~(a[1] ^ a[0]);
        big_b = ~(b[1] ^ b[0]);
        same  = ~(a[1] ^ b[1]);
        unique case ({big_a, big_b})
            2'b11:   r = same ? 4'd9 : 4'd0;
            2'b00:   r = same ? 4'd5 : 4'd4;
            default: r = same ? 4'd6 : 4'd3;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lagcorr_delay_line.sv
module lagcorr_delay_line #(
    parameter int NUM_LAGS = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         smp_vld,
    input  logic                         lead_en,
    input  logic [1:0]                   y_smp,
    output logic [NUM_LAGS-1:0][1:0]     taps
);
    localparam int SR_N = NUM_LAGS - 1;

    typedef struct packed {
        logic [1:0]            lead;
        logic [SR_N-1:0][1:0]  sr;
    } dl_st_t;

    dl_st_t st_d, st_q;
    logic [1:0] chain_in;

    always_comb begin
        chain_in = lead_en ? st_q.lead : y_smp;
    end

    always_comb begin
        st_d = st_q;
        if (smp_vld) begin
            st_d.lead  = y_smp;
            st_d.sr[0] = chain_in;
            for (int k = 1; k < SR_N; k++) begin
                st_d.sr[k] = st_q.sr[k-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        taps[0] = chain_in;
        for (int k = 1; k < NUM_LAGS; k++) begin
            taps[k] = st_q.sr[k-1];
        end
    end

endmodule

// File: rtl/lagcorr_lag_cell.sv
module lagcorr_lag_cell #(
    parameter int FAST_W = 5,
    parameter int PRE_W  = 4,
    parameter int TOT_W  = 20,
    parameter int OUT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        x_smp,
    input  logic [1:0]        y_tap,
    input  logic              acc_en,
    input  logic              dump,
    output logic [OUT_W-1:0]  stor
);
    localparam int UP_W = TOT_W - FAST_W - PRE_W;
    localparam logic [TOT_W:0] SAT_LIM = (TOT_W+1)'((64'd1 << OUT_W) - 64'd1);

    typedef struct packed {
        logic [3:0]        pend;
        logic [FAST_W-1:0] fast;
        logic [PRE_W-1:0]  pre;
        logic [UP_W-1:0]   up;
        logic [OUT_W-1:0]  stor;
    } lc_st_t;

    lc_st_t st_d, st_q;
    logic [TOT_W:0]    sum;
    logic [FAST_W:0]   fast_sum;
    logic [PRE_W:0]    pre_sum;

    always_comb begin
        st_d     = st_q;
        sum      = {1'b0, st_q.up, st_q.pre, st_q.fast} + (TOT_W+1)'(st_q.pend);
        fast_sum = {1'b0, st_q.fast} + (FAST_W+1)'(st_q.pend);
        pre_sum  = {1'b0, st_q.pre} + (PRE_W+1)'(1);
        if (dump) begin
            st_d.stor = (sum > SAT_LIM) ? '1 : sum[OUT_W-1:0];
            st_d.fast = '0;
            st_d.pre  = '0;
            st_d.up   = '0;
        end else begin
            st_d.fast = fast_sum[FAST_W-1:0];
            if (fast_sum[FAST_W]) begin
                st_d.pre = pre_sum[PRE_W-1:0];
                if (pre_sum[PRE_W] && (st_q.up != '1)) begin
                    st_d.up = st_q.up + UP_W'(1);
                end
            end
        end
        st_d.pend = acc_en ? lagcorr_pkg::prod_code(x_smp, y_tap) : 4'd0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stor = st_q.stor;

endmodule

// File: rtl/lagcorr_readout.sv
module lagcorr_readout #(
    parameter int NUM_LAGS = 64,
    parameter int OUT_W    = 16,
    parameter int IDX_W    = 6
) (
    input  logic [NUM_LAGS-1:0][OUT_W-1:0] stor_all,
    input  logic [IDX_W-1:0]               rd_idx,
    output logic [OUT_W-1:0]               rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [OUT_W-1:0] padded [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_pad
        if (g < NUM_LAGS) begin : g_live
            assign padded[g] = stor_all[g];
        end else begin : g_empty
            assign padded[g] = '0;
        end
    end

    assign rd_data = padded[rd_idx];

endmodule

// File: rtl/lagcorr_top.sv
module lagcorr_top #(
    parameter int NUM_LAGS = 64,
    parameter int FAST_W   = 5,
    parameter int PRE_W    = 4,
    parameter int TOT_W    = 20,
    parameter int OUT_W    = 16,
    parameter int IDX_W    = (NUM_LAGS > 1) ? $clog2(NUM_LAGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       x_smp,
    input  logic [1:0]       y_smp,
    input  logic             smp_vld,
    input  logic             blank,
    input  logic             dump,
    input  logic             lead_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [OUT_W-1:0] rd_data
);
    logic [NUM_LAGS-1:0][1:0]       taps;
    logic [NUM_LAGS-1:0][OUT_W-1:0] stor_all;
    logic                           acc_en;

    always_comb begin
        acc_en = smp_vld & ~blank & ~dump;
    end

    lagcorr_delay_line #(.NUM_LAGS(NUM_LAGS)) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_vld (smp_vld),
        .lead_en (lead_en),
        .y_smp   (y_smp),
        .taps    (taps)
    );

    for (genvar i = 0; i < NUM_LAGS; i++) begin : g_lag
        lagcorr_lag_cell #(
            .FAST_W (FAST_W),
            .PRE_W  (PRE_W),
            .TOT_W  (TOT_W),
            .OUT_W  (OUT_W)
        ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .x_smp  (x_smp),
            .y_tap  (taps[i]),
            .acc_en (acc_en),
            .dump   (dump),
            .stor   (stor_all[i])
        );
    end

    lagcorr_readout #(
        .NUM_LAGS (NUM_LAGS),
        .OUT_W    (OUT_W),
        .IDX_W    (IDX_W)
    ) u_rd (
        .stor_all (stor_all),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/lagcorr_checker.sv
module lagcorr_checker #(
    parameter int OUT_W = 16,
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_vld,
    input logic             blank,
    input logic             dump,
    input logic [IDX_W-1:0] rd_idx,
    input logic [OUT_W-1:0] rd_data
);
    localparam longint MAXV = (64'd1 << OUT_W) - 1;

    logic [31:0]      acc_cnt_q;
    logic             seen_dump_q;
    logic [OUT_W-1:0] bnd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_cnt_q   <= '0;
            seen_dump_q <= 1'b0;
        end else begin
            if (dump) begin
                acc_cnt_q   <= '0;
                seen_dump_q <= 1'b1;
            end else if (smp_vld && !blank && acc_cnt_q != '1) begin
                acc_cnt_q <= acc_cnt_q + 32'd1;
            end
        end
    end

    always_comb begin
        if (longint'(acc_cnt_q) * 9 > MAXV) bnd = '1;
        else bnd = OUT_W'(longint'(acc_cnt_q) * 9);
    end

    // R9: storage reads zero until the first dump
    assert_reset_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_dump_q |-> rd_data == '0);

    // R10: readout holds between dumps for a fixed index
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dump |=> ($stable(rd_data) || !$stable(rd_idx)));

    // R6 / R5: a stored word never exceeds 9 per accepted sample of its interval
    assert_dump_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dump |=> rd_data <= $past(bnd));

    // R11: readout is always a defined value
    assert_known_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(rd_data));

endmodule

bind lagcorr_top lagcorr_checker #(.OUT_W(OUT_W), .IDX_W(IDX_W)) u_lagcorr_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_vld (smp_vld),
    .blank   (blank),
    .dump    (dump),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
);

// File: tb/lagcorr_top_bench.sv
`timescale 1ns/1ps
module lagcorr_top_bench;
    localparam int N  = 64;
    localparam int OW = 16;
    localparam int IW = 6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n;
    logic [1:0]    x_smp, y_smp;
    logic          smp_vld, blank, dump, lead_en;
    logic [IW-1:0] rd_idx;
    logic [OW-1:0] rd_data;

    lagcorr_top u_lagcorr_top (
        .clk(clk), .rst_n(rst_n), .x_smp(x_smp), .y_smp(y_smp),
        .smp_vld(smp_vld), .blank(blank), .dump(dump), .lead_en(lead_en),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // reference model
    int hist [0:N+1];
    int acc  [N];
    int pend [N];
    int stor [N];
    bit lead;

    typedef struct { int idx; int exp; string tag; } item_t;
    item_t sb [$];

    logic [15:0] lf = 16'hACE1;

    function automatic int lvl(logic [1:0] s);
        case (s)
            2'b00: return -3;
            2'b01: return -1;
            2'b10: return 1;
            default: return 3;
        endcase
    endfunction

    function automatic int pcode(logic [1:0] a, logic [1:0] b);
        return (lvl(a) * lvl(b) + 9) / 2;
    endfunction

    task automatic model_edge(logic [1:0] x, logic [1:0] y, bit v, bit b, bit d);
        for (int k = 0; k < N; k++) begin
            int j;
            int yv;
            j  = k + int'(lead);
            yv = (j == 0) ? int'(y) : hist[j];
            if (d) begin
                stor[k] = (acc[k] + pend[k] > 65535) ? 65535 : acc[k] + pend[k];
                acc[k]  = 0;
            end else begin
                acc[k] = acc[k] + pend[k];
            end
            pend[k] = (v && !b && !d) ? pcode(x, 2'(yv)) : 0;
        end
        if (v) begin
            for (int j = N + 1; j > 1; j--) hist[j] = hist[j-1];
            hist[1] = int'(y);
        end
    endtask

    task automatic step(logic [1:0] x, logic [1:0] y, bit v, bit b, bit d);
        @(negedge clk);
        x_smp = x; y_smp = y; smp_vld = v; blank = b; dump = d;
        model_edge(x, y, v, b, d);
        @(posedge clk);
    endtask

    task automatic do_reset(bit ld);
        @(negedge clk);
        rst_n = 1'b0; x_smp = '0; y_smp = '0; smp_vld = 0; blank = 0; dump = 0;
        rd_idx = '0; lead_en = ld; lead = ld;
        for (int j = 0; j < N + 2; j++) hist[j] = 0;
        for (int k = 0; k < N; k++) begin acc[k] = 0; pend[k] = 0; stor[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // driver side: push expected storage words
    task automatic expect_all(string tag);
        for (int k = 0; k < N; k++) sb.push_back('{k, stor[k], tag});
    endtask

    // monitor side: pop and compare against the readout port
    task automatic drain();
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            @(negedge clk);
            x_smp = '0; y_smp = '0; smp_vld = 0; blank = 0; dump = 0;
            model_edge(2'b00, 2'b00, 0, 0, 0);
            rd_idx = IW'(it.idx);
            #1;
            total++;
            if (int'(rd_data) != it.exp) begin
                bad++;
                $display("FAIL %s lag=%0d actual=%0d expected=%0d", it.tag, it.idx, rd_data, it.exp);
            end
        end
    endtask

    task automatic rand_run(int n, bit with_blank);
        for (int i = 0; i < n; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[1:0], lf[3:2], lf[6:4] != 3'd0, with_blank && (lf[9:7] == 3'd0), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL R11 watchdog actual=timeout expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        do_reset(0);
        expect_all("R9");
        drain();

        // R1: every code pair on lag 0, one sample per interval
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                step(2'(a), 2'(b), 1, 0, 0);
                step(2'b00, 2'b00, 0, 0, 1);
                sb.push_back('{0, pcode(2'(a), 2'(b)), "R1"});
                drain();
            end
        end

        // R2, R4, R5: long mixed interval with gaps and blanking
        do_reset(0);
        rand_run(300, 1);
        step(2'b00, 2'b00, 0, 0, 1);
        expect_all("R2 R4 R5");
        drain();

        // R7: dump lands on a valid sample, right after another valid one
        rand_run(120, 0);
        step(2'b11, 2'b11, 1, 0, 1);
        expect_all("R7");
        drain();

        // R6: next interval starts from zero
        rand_run(90, 1);
        step(2'b00, 2'b00, 0, 0, 1);
        expect_all("R6");
        drain();

        // R10: samples without dump leave storage untouched
        rand_run(40, 0);
        expect_all("R10");
        drain();

        // R3: lead stage inserted
        do_reset(1);
        rand_run(200, 1);
        step(2'b00, 2'b00, 0, 0, 1);
        expect_all("R3");
        drain();

        // R8: saturation of the stored word
        do_reset(0);
        for (int i = 0; i < 7400; i++) step(2'b11, 2'b11, 1, 0, 0);
        step(2'b00, 2'b00, 0, 0, 1);
        expect_all("R8");
        drain();

        // R11: readout tracks the index within a cycle
        for (int k = N - 1; k >= 0; k--) sb.push_back('{k, stor[k], "R11"});
        drain();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule